// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a synchronous sequencer that runs accesses to an external 32K x 8 asynchronous static RAM for a host that posts one byte request at a time. A request carries a write flag, a 15-bit address and a write byte. The controller turns it into the memory's strobe sequence: an active-low chip select, an active-low output enable and an active-low write enable. It also controls the data pins, with a separate drive-enable so that a pad ring or board-level buffer can build the bidirectional bus.

Every phase length is a number of clock cycles. The read access, write strobe and bus turnaround counts are derived at elaboration time from the clock period and the memory's nanosecond limits, rounded up, with a minimum of one cycle. The write setup and write hold counts are given directly. The address is captured when a request is accepted and stays fixed until the access completes.

The request side is a valid/ready stream. The host holds `req_valid` and its payload until a cycle in which `req_ready` is also high, and the request is taken on that clock edge. `req_ready` is high only while the controller is idle, so a request that waits is simply back-pressured. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that ends every access. For a read, `rsp_rdata` holds the captured byte from that pulse until the next read captures new data.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Out of reset and whenever idle, chip select, output enable and write enable are all high (inactive), the data drive-enable is low, and `req_ready` is 1.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. From that edge until the access returns to idle, `req_ready` is 0, and any change on the request inputs has no effect on the access in progress.
- R3: A read holds chip select low, output enable low and write enable high for ACC cycles, where ACC = max(1, ceil(max(tRC, tAA, tOE)/period)). The address equals the accepted address and the data drive-enable stays low throughout.
- R4: The read byte is the memory data bus sampled on the clock edge that ends the last access cycle. It appears on `rsp_rdata` from that edge on, and holds until the next read captures. Its reset value is 0.
- R5: After the read access, output enable goes high while chip select stays low for TURN cycles, where TURN = max(1, ceil(tOHZ/period)). Chip select never rises in a cycle whose previous cycle had output enable low.
- R6: A write drives the accepted byte with drive-enable 1, chip select low and output enable high, and holds write enable high for SETUP_CYC cycles before the strobe.
- R7: Write enable is then low for WP cycles, where WP = max(1, ceil(tWP/period), ceil(tCW/period), ceil(tDW/period), ceil(tWC/period) - SETUP_CYC - HOLD_CYC). It then returns high for HOLD_CYC cycles with the address, data and chip select unchanged.
- R8: Each access ends with exactly one cycle in which `rsp_valid` is 1. In that cycle all strobes are high and the bus is released, and the next cycle is idle. Chip select is therefore high for at least two cycles between accesses.
- R9: The measured low time of output enable in a read, and of write enable in a write, equals the derived cycle count. That count times the clock period meets the corresponding nanosecond limit.
- R10: The data drive-enable is never 1 in a cycle where output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready, high only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle access-complete pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 15 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The controller runs with a slow timing set, which makes the read access three cycles, the strobe two, the turnaround two and the setup two, so that an off-by-one in any phase shows up. Isolated writes and reads at the lowest and highest addresses and at an unwritten address show whether the strobe order and data path are right. The memory model drives valid data only in the final access cycle, so a capture made one edge early is visible. Back-to-back requests with valid held high show that the idle gap and back-pressure work. Junk on the request lines while busy shows that the latched address and data are immune to them. A stream of random mixed accesses checks read-after-write coherence.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RD_ACC    = 3'd1,
    ST_RD_TURN   = 3'd2,
    ST_WR_SETUP  = 3'd3,
    ST_WR_STROBE = 3'd4,
    ST_WR_HOLD   = 3'd5,
    ST_DONE      = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
    logic done;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, done: 1'b0};

  // Cycles needed to cover a nanosecond limit, never fewer than one.
  function automatic int ns_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Write strobe length: pulse width, select-to-end, data setup, and the
  // part of the write cycle time not already covered by setup and hold.
  function automatic int strobe_cycles(input int t_wp, input int t_cw, input int t_dw,
                                       input int t_wc, input int period,
                                       input int su, input int hd);
    int m;
    int rest;
    m    = imax(ns_cycles(t_wp, period), imax(ns_cycles(t_cw, period), ns_cycles(t_dw, period)));
    rest = ((t_wc + period - 1) / period) - su - hd;
    return imax(m, rest);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  // Last cycle of the current phase.
  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW        = 2,
  parameter int ACC_CYC   = 1,
  parameter int TURN_CYC  = 1,
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_fire,
  input  logic          req_write,
  input  logic          expired,
  output seq_state_e    state_q,
  output seq_state_e    state_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  localparam logic [CW-1:0] ACC_M1  = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] TURN_M1 = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] SU_M1   = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] WP_M1   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] HD_M1   = CW'(HOLD_CYC - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
            tmr_val = SU_M1;
          end else begin
            state_d = ST_RD_ACC;
            tmr_val = ACC_M1;
          end
        end
      end
      ST_RD_ACC: begin
        if (expired) begin
          state_d  = ST_RD_TURN;
          tmr_load = 1'b1;
          tmr_val  = TURN_M1;
        end
      end
      ST_RD_TURN: begin
        if (expired) state_d = ST_DONE;
      end
      ST_WR_SETUP: begin
        if (expired) begin
          state_d  = ST_WR_STROBE;
          tmr_load = 1'b1;
          tmr_val  = WP_M1;
        end
      end
      ST_WR_STROBE: begin
        if (expired) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HD_M1;
        end
      end
      ST_WR_HOLD: begin
        if (expired) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  pin_ctl_t pins_d;
  pin_ctl_t pins_q;

  // Strobe pattern of the state about to be entered, so that the pins
  // switch on the same edge as the state register.
  always_comb begin
    pins_d = PINS_IDLE;
    unique case (state_d)
      ST_RD_ACC:    pins_d = '{cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0, done: 1'b0};
      ST_RD_TURN:   pins_d = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, done: 1'b0};
      ST_WR_SETUP:  pins_d = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1, done: 1'b0};
      ST_WR_STROBE: pins_d = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1, done: 1'b0};
      ST_WR_HOLD:   pins_d = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1, done: 1'b0};
      ST_DONE:      pins_d = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, done: 1'b1};
      default:      pins_d = PINS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_IDLE;
    else        pins_q <= pins_d;
  end

  // Address and write byte are frozen at acceptance for the whole access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (req_fire) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (cap_en) rsp_rdata <= mem_dq_i;
  end

  assign mem_cs_n  = pins_q.cs_n;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_dq_oe = pins_q.dq_oe;
  assign rsp_valid = pins_q.done;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 20,
  parameter int T_AA_NS       = 20,
  parameter int T_OE_NS       = 10,
  parameter int T_WC_NS       = 20,
  parameter int T_WP_NS       = 15,
  parameter int T_CW_NS       = 15,
  parameter int T_DW_NS       = 11,
  parameter int T_OHZ_NS      = 8,
  parameter int SETUP_CYC     = 1,
  parameter int HOLD_CYC      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int ACC_CYC  = imax(ns_cycles(T_RC_NS, CLK_PERIOD_NS),
                                 imax(ns_cycles(T_AA_NS, CLK_PERIOD_NS),
                                      ns_cycles(T_OE_NS, CLK_PERIOD_NS)));
  localparam int TURN_CYC = ns_cycles(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int WP_CYC   = strobe_cycles(T_WP_NS, T_CW_NS, T_DW_NS, T_WC_NS,
                                           CLK_PERIOD_NS, SETUP_CYC, HOLD_CYC);
  localparam int SU_CYC   = imax(SETUP_CYC, 1);
  localparam int HD_CYC   = imax(HOLD_CYC, 1);
  localparam int MAX_CYC  = imax(imax(ACC_CYC, TURN_CYC), imax(WP_CYC, imax(SU_CYC, HD_CYC)));
  localparam int CW       = $clog2(MAX_CYC + 1);

  seq_state_e    state_q;
  seq_state_e    state_d;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          expired;
  logic          req_fire;
  logic          cap_en;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign cap_en    = (state_q == ST_RD_ACC) && expired;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sram_seq_fsm #(
    .CW        (CW),
    .ACC_CYC   (ACC_CYC),
    .TURN_CYC  (TURN_CYC),
    .SETUP_CYC (SU_CYC),
    .WP_CYC    (WP_CYC),
    .HOLD_CYC  (HD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_write (req_write),
    .expired   (expired),
    .state_q   (state_q),
    .state_d   (state_d),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .req_fire  (req_fire),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_en    (cap_en),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !mem_cs_n));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  p_oe_before_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> $past(mem_oe_n));

  p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  p_strobe_context_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

  p_done_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_cs_n && !mem_dq_oe));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_bus_ctrl_test.sv
`timescale 1ns/1ps
module sram_bus_ctrl_test;

  localparam int PER   = 20;
  localparam int TRC   = 45;
  localparam int TAA   = 45;
  localparam int TOE   = 20;
  localparam int TWC   = 45;
  localparam int TWP   = 35;
  localparam int TCW   = 40;
  localparam int TDW   = 20;
  localparam int TOHZ  = 25;
  localparam int SU_C  = 2;
  localparam int HD_C  = 1;
  // Expected phase lengths for this timing set, worked out by hand (R9):
  // access ceil(45/20)=3, strobe max(ceil(35/20),ceil(40/20))=2, turn ceil(25/20)=2.
  localparam int ACC_C  = 3;
  localparam int WP_C   = 2;
  localparam int TURN_C = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  always #10 clk = ~clk;

  sram_bus_ctrl #(
    .CLK_PERIOD_NS(PER), .T_RC_NS(TRC), .T_AA_NS(TAA), .T_OE_NS(TOE),
    .T_WC_NS(TWC), .T_WP_NS(TWP), .T_CW_NS(TCW), .T_DW_NS(TDW),
    .T_OHZ_NS(TOHZ), .SETUP_CYC(SU_C), .HOLD_CYC(HD_C)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [7:0] mem [int];
  int rd_age = 0;

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  wire read_mode = (mem_cs_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);

  // Data is valid only once the access has lasted ACC_C cycles.
  always @(negedge clk) rd_age <= read_mode ? rd_age + 1 : 0;

  always @* mem_dq_i = (read_mode && rd_age >= ACC_C) ? mem_rd(mem_addr) : 8'hEE;

  always @(posedge mem_we_n)
    if (mem_cs_n === 1'b0 && mem_dq_oe === 1'b1) mem[int'(mem_addr)] = mem_dq_o;

  // ---------------- cycle reference model ----------------
  typedef struct {
    logic        cs_n, oe_n, we_n, dq_oe, done, idle, upd;
    logic [14:0] addr;
    logic [7:0]  dq;
    logic [7:0]  rd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] exp_rdata = 8'h00;
  exp_t e;
  exp_t v;
  int we_len = 0;
  int oe_len = 0;

  task automatic push_txn(input bit w, input logic [14:0] a, input logic [7:0] d);
    exp_t x;
    x.idle = 1'b0; x.upd = 1'b0; x.addr = a; x.dq = d; x.rd = 8'h00; x.done = 1'b0;
    if (w) begin
      x.cs_n = 0; x.oe_n = 1; x.we_n = 1; x.dq_oe = 1; x.tag = "R6";
      for (int i = 0; i < SU_C; i++) exp_q.push_back(x);
      x.we_n = 0; x.tag = "R7";
      for (int i = 0; i < WP_C; i++) exp_q.push_back(x);
      x.we_n = 1;
      for (int i = 0; i < HD_C; i++) exp_q.push_back(x);
    end else begin
      x.cs_n = 0; x.oe_n = 0; x.we_n = 1; x.dq_oe = 0; x.tag = "R3";
      for (int i = 0; i < ACC_C; i++) exp_q.push_back(x);
      x.oe_n = 1; x.tag = "R5";
      for (int i = 0; i < TURN_C; i++) begin
        x.upd = (i == 0);
        x.rd  = mem_rd(a);
        exp_q.push_back(x);
      end
      x.upd = 1'b0;
    end
    x.cs_n = 1; x.oe_n = 1; x.we_n = 1; x.dq_oe = 0; x.done = 1; x.tag = "R8";
    exp_q.push_back(x);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin
        e.cs_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0; e.done = 0;
        e.idle = 1; e.upd = 0; e.addr = '0; e.dq = '0; e.rd = '0; e.tag = "R1";
      end
      if (e.upd) exp_rdata = e.rd;
      check(mem_cs_n === e.cs_n, e.tag, "cs_n", 32'(mem_cs_n), 32'(e.cs_n));
      check(mem_oe_n === e.oe_n, e.tag, "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
      check(mem_we_n === e.we_n, e.tag, "we_n", 32'(mem_we_n), 32'(e.we_n));
      check(mem_dq_oe === e.dq_oe, e.tag, "dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe));
      check(rsp_valid === e.done, "R8", "rsp_valid", 32'(rsp_valid), 32'(e.done));
      check(req_ready === e.idle, "R2", "req_ready", 32'(req_ready), 32'(e.idle));
      if (!e.cs_n) check(mem_addr === e.addr, e.tag, "addr", 32'(mem_addr), 32'(e.addr));
      if (e.dq_oe) check(mem_dq_o === e.dq, "R6", "write data", 32'(mem_dq_o), 32'(e.dq));
      check(rsp_rdata === exp_rdata, "R4", "rsp_rdata", 32'(rsp_rdata), 32'(exp_rdata));
      check(!(mem_dq_oe === 1'b1 && mem_oe_n === 1'b0), "R10", "contention",
            32'(mem_dq_oe), 32'(0));
      // R9: strobe lengths measured at the pins
      if (mem_we_n === 1'b0) we_len++;
      else if (we_len != 0) begin
        check(we_len == WP_C && we_len * PER >= TWP, "R9", "we low cycles", 32'(we_len), 32'(WP_C));
        we_len = 0;
      end
      if (mem_oe_n === 1'b0) oe_len++;
      else if (oe_len != 0) begin
        check(oe_len == ACC_C && oe_len * PER >= TAA, "R9", "oe low cycles", 32'(oe_len), 32'(ACC_C));
        oe_len = 0;
      end
      if (req_valid && req_ready) push_txn(req_write, req_addr, req_wdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit w, input logic [14:0] a, input logic [7:0] d, input bit keep);
    bit fired;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    fired = 1'b0;
    while (!fired) begin
      @(negedge clk);
      fired = req_ready;
      @(posedge clk);
    end
    #1;
    if (!keep) begin
      req_valid = 1'b0;
      // R2: junk on the request lines while busy must not reach the access
      req_write = ~w;
      req_addr  = 15'($urandom);
      req_wdata = 8'($urandom);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    check(mem_cs_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1", "reset strobes",
          {29'd0, mem_cs_n, mem_oe_n, mem_we_n}, 32'h7);
    check(mem_dq_oe === 1'b0, "R1", "reset drive", 32'(mem_dq_oe), 32'h0);
    check(rsp_valid === 1'b0 && rsp_rdata === 8'h00, "R4", "reset response",
          {23'd0, rsp_valid, rsp_rdata}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    do_req(1'b1, 15'h0000, 8'h11, 1'b0);
    do_req(1'b1, 15'h7FFF, 8'hEE, 1'b0);
    do_req(1'b1, 15'h1234, 8'hA5, 1'b0);
    drain();
    do_req(1'b0, 15'h1234, 8'h00, 1'b0);
    do_req(1'b0, 15'h0000, 8'h00, 1'b0);
    do_req(1'b0, 15'h7FFF, 8'h00, 1'b0);
    do_req(1'b0, 15'h0555, 8'h00, 1'b0);
    drain();
    // back-to-back with valid held high
    do_req(1'b1, 15'h2AAA, 8'h3C, 1'b1);
    do_req(1'b0, 15'h2AAA, 8'h00, 1'b1);
    do_req(1'b1, 15'h2AAA, 8'hC3, 1'b1);
    do_req(1'b0, 15'h2AAA, 8'h00, 1'b0);
    drain();
    for (int i = 0; i < 40; i++) begin
      logic [14:0] a;
      a = {11'd0, 4'($urandom)};
      do_req(1'($urandom), a, 8'($urandom), 1'($urandom));
    end
    req_valid = 1'b0;
    drain();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule